// File: doc/BRIEF.md
# Companded PCM Attenuation Pad

This block sits on the receive path of one 64 kbps companded voice channel, after the point where a decoded 8-bit PCM code is available and before it is serialised. Each code passes through one of four treatments chosen by a 2-bit pad control: unchanged, 6 dB quieter, 12 dB quieter, or replaced by the idle code that marks the channel as out of service. A static law input picks µ-law or A-law coding.

Attenuation happens in the linear domain. The code is expanded to a signed linear magnitude, the magnitude is shifted right, and the result is compressed back under the same law. The pad control is not used live. It is sampled once per 8 kHz frame, on the rising edge of the PCM frame sync, and held in a mode register until the next rising edge. This lets a controller change the pad setting at any time without corrupting a sample partway through a frame.

Top module: `pcmPadAtten`

## Requirements
- R1: While `rstN` is low at a clock edge, the registered mode returns to pass-through and `pcmOut` becomes the idle code of the current law.
- R2: In pass-through mode (control 2'b00), `pcmOut` after a clock edge equals `pcmIn` sampled at that edge.
- R3: In the 6 dB mode (control 2'b01), the output is the input code expanded, its magnitude shifted right by one bit, and compressed under the same law.
- R4: In the 12 dB mode (control 2'b10), the output follows the same path as in R3, with a shift of two bits.
- R5: In the out-of-service mode (control 2'b11), the output is 8'hFF when µ-law is selected and 8'hD5 when A-law is selected, whatever the input.
- R6: With `lawSel` = 1 (A-law), a code is expanded after XOR with 8'h55. Bits [6:4] are the segment and [3:0] the step. Segment 0 gives magnitude 2·step+1, and segment s>0 gives (2·step+33)·2^(s-1).
- R7: With `lawSel` = 0 (µ-law), a code is expanded after inverting all bits. Bits [6:4] are the segment and [3:0] the step, and the magnitude is (2·step+33)·2^segment − 33.
- R8: The pad control is sampled only on a clock edge where `frameSync` is high and was low at the previous edge. Control changes at any other time, including while `frameSync` stays high, have no effect on the output.
- R9: Attenuation keeps the sign bit (bit 7) of the code. The magnitude is truncated toward zero, so a zero-magnitude code maps to itself.
- R10: Every output is registered one clock after its input. A newly captured mode applies from the edge after the capturing edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| lawSel | input | 1 | Coding law: 1 = A-law, 0 = µ-law (static) |
| frameSync | input | 1 | PCM frame sync, 8 kHz; the rising edge captures the pad control |
| padCtl | input | 2 | Pad control: 00 pass, 01 −6 dB, 10 −12 dB, 11 idle code |
| pcmIn | input | 8 | Companded PCM code from the decoder |
| pcmOut | output | 8 | Padded companded PCM code, registered |

## Verification
The bench sweeps all 256 codes in both laws through every mode. The sweep covers the segment boundaries, where a re-compressed magnitude must fall into the next lower segment. A compressor that picks the wrong segment or step would show up there. So would an expander with the wrong µ-law bias or the wrong A-law segment-0 rule. Codes with zero magnitude and the largest negative codes test the sign handling: a design that rounded away from zero, or lost the sign of negative zero, would change those outputs. Each frame holds sync high for two cycles while the control changes and then changes the control again mid-frame. A level-triggered or live-control design would switch modes too early. A reset in the middle of the run catches a mode register that survives reset.

// File: rtl/pcmPadPkg.sv
package pcmPadPkg;

  localparam int CODE_W      = 8;
  localparam int MAG_W       = 13;
  localparam int SEG_W       = 3;
  localparam int STEP_W      = 4;
  localparam int MU_BIAS     = 33;
  localparam int SEG_BASE    = 5;
  localparam int SHIFT_W     = 2;
  localparam int SHIFT_LOSS6 = 1;
  localparam int SHIFT_LOSS12 = 2;

  localparam logic [CODE_W-1:0] ALAW_TOGGLE = 8'h55;
  localparam logic [CODE_W-1:0] MU_IDLE     = 8'hFF;
  localparam logic [CODE_W-1:0] ALAW_IDLE   = 8'hD5;

  typedef enum logic [1:0] {
    PAD_PASS   = 2'b00,
    PAD_LOSS6  = 2'b01,
    PAD_LOSS12 = 2'b10,
    PAD_IDLE   = 2'b11
  } padMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic               passEn;
    logic               idleEn;
    logic [SHIFT_W-1:0] shiftAmt;
  } padCmd_s;

  function automatic logic [CODE_W-1:0] idleCode(input logic isAlaw);
    return isAlaw ? ALAW_IDLE : MU_IDLE;
  endfunction

endpackage

// File: rtl/padCtrl.sv
module padCtrl
  import pcmPadPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameSync,
  input  logic [1:0]    padCtl,
  output padCmd_s       padCmd
);

  logic     syncPrev;
  logic     syncRise;
  padMode_e modeReg;

  // Edge history is kept through reset so that the first edge after reset is a real edge.
  always_ff @(posedge clk) begin
    syncPrev <= frameSync;
  end

  assign syncRise = frameSync & ~syncPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= PAD_PASS;
    end else if (syncRise) begin
      modeReg <= padMode_e'(padCtl);
    end
  end

  always_comb begin
    padCmd          = '0;
    padCmd.passEn   = (modeReg == PAD_PASS);
    padCmd.idleEn   = (modeReg == PAD_IDLE);
    unique case (modeReg)
      PAD_LOSS6:  padCmd.shiftAmt = SHIFT_W'(SHIFT_LOSS6);
      PAD_LOSS12: padCmd.shiftAmt = SHIFT_W'(SHIFT_LOSS12);
      default:    padCmd.shiftAmt = '0;
    endcase
  end

endmodule

// File: rtl/pcmExpand.sv
module pcmExpand
  import pcmPadPkg::*;
#(
  parameter bit IS_ALAW = 1'b0
) (
  input  logic [CODE_W-1:0] code,
  output logic              signBit,
  output logic [MAG_W-1:0]  mag
);

  logic [CODE_W-1:0] raw;
  logic [SEG_W-1:0]  seg;
  logic [STEP_W-1:0] step;
  logic [MAG_W-1:0]  base;

  assign signBit = code[CODE_W-1];
  assign seg     = raw[CODE_W-2 -: SEG_W];
  assign step    = raw[STEP_W-1:0];
  // 2*step + 33, common to both laws
  assign base    = MAG_W'({step, 1'b1}) + MAG_W'(32);

  generate
    if (IS_ALAW) begin : gAlaw
      assign raw = code ^ ALAW_TOGGLE;
      always_comb begin
        if (seg == '0) mag = MAG_W'({step, 1'b1});
        else           mag = base << (seg - SEG_W'(1));
      end
    end else begin : gMulaw
      assign raw = ~code;
      always_comb begin
        mag = (base << seg) - MAG_W'(MU_BIAS);
      end
    end
  endgenerate

endmodule

// File: rtl/pcmCompress.sv
module pcmCompress
  import pcmPadPkg::*;
#(
  parameter bit IS_ALAW = 1'b0
) (
  input  logic              signBit,
  input  logic [MAG_W-1:0]  mag,
  output logic [CODE_W-1:0] code
);

  logic [MAG_W-1:0]  biased;
  logic [SEG_W-1:0]  seg;
  logic [STEP_W-1:0] step;

  generate
    if (IS_ALAW) begin : gAlaw
      assign biased = mag;
      always_comb begin
        seg = '0;
        for (int p = SEG_BASE; p < MAG_W - 1; p++) begin
          if (biased[p]) seg = SEG_W'(p - SEG_BASE + 1);
        end
        if (seg == '0) step = STEP_W'(biased >> 1);
        else           step = STEP_W'(biased >> seg);
      end
      assign code = {signBit, {seg, step} ^ ALAW_TOGGLE[CODE_W-2:0]};
    end else begin : gMulaw
      assign biased = mag + MAG_W'(MU_BIAS);
      always_comb begin
        seg = '0;
        for (int p = SEG_BASE; p < MAG_W; p++) begin
          if (biased[p]) seg = SEG_W'(p - SEG_BASE);
        end
        step = STEP_W'(biased >> ({1'b0, seg} + 4'd1));
      end
      assign code = {signBit, ~{seg, step}};
    end
  endgenerate

endmodule

// File: rtl/padDatapath.sv
module padDatapath
  import pcmPadPkg::*;
#(
  parameter int NUM_LAWS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lawSel,
  input  padCmd_s           padCmd,
  input  logic [CODE_W-1:0] pcmIn,
  output logic [CODE_W-1:0] pcmOut
);

  logic [CODE_W-1:0] laneCode [NUM_LAWS];

  // One expand/shift/compress lane per law; index 1 is A-law
  for (genvar g = 0; g < NUM_LAWS; g++) begin : gLane
    logic             laneSign;
    logic [MAG_W-1:0] laneMag;
    logic [MAG_W-1:0] laneScaled;

    pcmExpand #(.IS_ALAW(g == 1)) u_expand (
      .code    (pcmIn),
      .signBit (laneSign),
      .mag     (laneMag)
    );

    assign laneScaled = laneMag >> padCmd.shiftAmt;

    pcmCompress #(.IS_ALAW(g == 1)) u_compress (
      .signBit (laneSign),
      .mag     (laneScaled),
      .code    (laneCode[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcmOut <= idleCode(lawSel);
    end else if (padCmd.idleEn) begin
      pcmOut <= idleCode(lawSel);
    end else if (padCmd.passEn) begin
      pcmOut <= pcmIn;
    end else begin
      pcmOut <= laneCode[lawSel];
    end
  end

endmodule

// File: rtl/pcmPadAtten.sv
module pcmPadAtten
  import pcmPadPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lawSel,
  input  logic       frameSync,
  input  logic [1:0] padCtl,
  input  logic [7:0] pcmIn,
  output logic [7:0] pcmOut
);

  padCmd_s padCmd;

  padCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .padCtl    (padCtl),
    .padCmd    (padCmd)
  );

  padDatapath #(.NUM_LAWS(2)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .lawSel (lawSel),
    .padCmd (padCmd),
    .pcmIn  (pcmIn),
    .pcmOut (pcmOut)
  );

endmodule

// File: rtl/padChecker.sv
module padChecker
  import pcmPadPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       lawSel,
  input logic       frameSync,
  input logic [1:0] padCtl,
  input logic [7:0] pcmIn,
  input logic [7:0] pcmOut,
  input padCmd_s    padCmd
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> pcmOut == ($past(lawSel) ? 8'hD5 : 8'hFF));

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    padCmd.passEn |=> pcmOut == $past(pcmIn));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    padCmd.idleEn |=> pcmOut == ($past(lawSel) ? 8'hD5 : 8'hFF));

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSync) |=> padCmd.idleEn == ($past(padCtl) == 2'b11));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(frameSync) |=> $stable(padCmd));

  assert_sign_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (padCmd.shiftAmt != '0) |=> pcmOut[7] == $past(pcmIn[7]));

endmodule

bind pcmPadAtten padChecker u_padChecker (
  .clk       (clk),
  .rstN      (rstN),
  .lawSel    (lawSel),
  .frameSync (frameSync),
  .padCtl    (padCtl),
  .pcmIn     (pcmIn),
  .pcmOut    (pcmOut),
  .padCmd    (padCmd)
);

// File: tb/pcmPadAtten_bench.sv
`timescale 1ns/1ps
module pcmPadAtten_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lawSel = 1'b0;
  logic       frameSync = 1'b0;
  logic [1:0] padCtl = 2'b00;
  logic [7:0] pcmIn = 8'h00;
  logic [7:0] pcmOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #2.5 clk = ~clk;

  pcmPadAtten u_pcmPadAtten (
    .clk       (clk),
    .rstN      (rstN),
    .lawSel    (lawSel),
    .frameSync (frameSync),
    .padCtl    (padCtl),
    .pcmIn     (pcmIn),
    .pcmOut    (pcmOut)
  );

  // ---------- behavioural reference ----------
  function automatic int expandMag(input int code, input bit aLaw);
    int v, seg, step;
    v    = aLaw ? (code ^ 'h55) : (~code & 'hFF);
    seg  = (v / 16) % 8;
    step = v % 16;
    if (aLaw) return (seg == 0) ? (2 * step + 1) : (2 * step + 33) * (2 ** (seg - 1));
    return (2 * step + 33) * (2 ** seg) - 33;  // R7
  endfunction

  function automatic int compressCode(input int signBit, input int mag, input bit aLaw);
    int x, seg, step;
    if (aLaw) begin  // R6
      if (mag < 32) begin seg = 0; step = mag / 2; end
      else begin
        seg = 1;
        while (seg < 7 && mag >= 64 * (2 ** (seg - 1))) seg++;
        step = (mag / (2 ** seg)) % 16;
      end
      return signBit * 128 + ((seg * 16 + step) ^ 'h55);
    end
    x = mag + 33;
    seg = 0;
    while (seg < 7 && x >= 64 * (2 ** seg)) seg++;
    step = (x / (2 ** (seg + 1))) % 16;
    return signBit * 128 + (127 - (seg * 16 + step));
  endfunction

  function automatic int refOut(input int code, input int mode, input bit aLaw);
    int sh;
    if (mode == 3) return aLaw ? 'hD5 : 'hFF;
    if (mode == 0) return code;
    sh = (mode == 1) ? 1 : 2;
    return compressCode(code / 128, expandMag(code, aLaw) / (2 ** sh), aLaw);  // R9 truncation
  endfunction

  int    expOut  = 0;
  int    expMode = 0;
  bit    prevSync = 0;
  string expTag  = "R1";

  // Reference updated on each rising edge; inputs only change on falling edges
  always @(posedge clk) begin
    if (!rstN) begin
      expOut  = lawSel ? 'hD5 : 'hFF;
      expMode = 0;
      expTag  = "R1";
    end else begin
      expOut = refOut(pcmIn, expMode, lawSel);
      case (expMode)
        0: expTag = "R2 R10";
        1: expTag = "R3 R9";
        2: expTag = "R4 R9";
        default: expTag = "R5";
      endcase
      expTag = {expTag, lawSel ? " R6" : " R7", " R8"};
      if (frameSync && !prevSync) expMode = padCtl;
    end
    prevSync = frameSync;
  end

  bit checkEn = 0;
  always @(negedge clk) begin
    if (checkEn && !finished) begin
      checkCount++;
      if (pcmOut !== 8'(expOut)) begin
        failCount++;
        $display("FAIL %s: pcmOut actual %02h expected %02h (pcmIn %02h law %0d)",
                 expTag, pcmOut, 8'(expOut), pcmIn, lawSel);
      end
    end
  end

  task automatic finishRun();
    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  // One frame: sync held two cycles with control changing on the second (R8),
  // then the control changes mid-frame while every code is swept.
  task automatic runFrame(input int mode);
    @(negedge clk); frameSync = 1'b1; padCtl = 2'(mode); pcmIn = 8'hFF;
    @(negedge clk); padCtl = 2'(mode ^ 3); pcmIn = 8'h7F;
    @(negedge clk); frameSync = 1'b0; padCtl = 2'(mode ^ 1);
    for (int c = 0; c < 256; c++) begin
      @(negedge clk); pcmIn = 8'(c);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkEn = 1;               // R1: outputs during reset
    @(negedge clk); rstN = 1'b1;
    for (int law = 0; law < 2; law++) begin
      @(negedge clk); lawSel = law[0];
      for (int m = 0; m < 4; m++) runFrame(m);
      runFrame(1);             // revisit a loss mode after idle
    end
    runFrame(3);
    @(negedge clk); rstN = 1'b0; pcmIn = 8'h42;   // R1 mid-run
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    for (int c = 0; c < 16; c++) begin            // back to pass-through
      @(negedge clk); pcmIn = 8'(c * 17);
    end
    @(negedge clk); @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checkCount++; failCount++;
      $display("FAIL R10: watchdog actual hung expected finished");
      finishRun();
    end
  end

endmodule